// File: doc/BRIEF.md
# Write-Masked Control Register Bank

This block is a small memory-mapped register file for controlling a storage-interface PHY. It holds seven 16-bit control registers and one read-only status word. Every write carries its own per-bit enable mask in the upper half of the 32-bit write word. Software can therefore set or clear any group of control bits in one bus write, with no read-modify-write sequence and no race with other agents that share the register.

Two control bits in the last control register drive the PHY directly. One is the active-high power-on control and the other is the delay-locked-loop enable. The status word reflects two live inputs from the PHY: calibration done and DLL ready. The bus side is a plain slave port with byte address, write data, a write strobe, a read strobe and a registered read-data output. Read data appears on the clock edge that samples the read strobe. It holds until the next read.

Top module: `wmask_regbank`

## Requirements
- R1: While `rst_n` is low, every control register, `ctrl_o`, `pwr_on_o`, `dll_en_o` and `rdata` are zero. This leaves the PHY powered down with its DLL disabled.
- R2: A write updates data bit x (0..15) of the addressed control register only when `wdata[x+16]` is 1. Bits whose enable is 0 keep their value. The result is visible on the next clock edge.
- R3: Control register k (k = 0..6) sits at byte address 4*k (0x00 to 0x18). A write to one control register leaves the other six unchanged.
- R4: A read of a control register returns its 16 stored bits in `rdata[15:0]` and zero in `rdata[31:16]`. `rdata` is updated on the edge that samples `rd_en` and holds its value while `rd_en` is low.
- R5: A read of byte address 0x20 returns `cal_done_i` in bit 6 and `dll_rdy_i` in bit 5, both as sampled at the read edge. All other bits of the read are zero.
- R6: A write to address 0x20, to any address above 0x18, or to any address with `addr[1:0]` not zero changes no control register.
- R7: A read of any address other than 0x00..0x18 (word aligned) or 0x20 returns zero.
- R8: `pwr_on_o` follows bit 0 and `dll_en_o` follows bit 1 of the control register at 0x18. Both change on the edge after the write that sets or clears them.
- R9: When a read and a write hit the same control register in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write word: [31:16] bit enables, [15:0] data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| cal_done_i | input | 1 | Calibration done from the PHY |
| dll_rdy_i | input | 1 | DLL ready from the PHY |
| ctrl_o | output | 112 | All control registers, register k in bits [16k+15:16k] |
| pwr_on_o | output | 1 | Power-on control to the PHY |
| dll_en_o | output | 1 | DLL enable to the PHY |

## Verification
The assertions check four rules on every cycle. Control bits change only where the write mask allowed it, and nothing changes without a valid control-register write. The upper half of read data is always zero, and status reads and unmapped reads return the right value. The PHY controls rise only after a matching write to 0x18. The bench's scenarios are needed for the rest: which register a given address reaches, the exact value after a series of partially masked writes, the read-before-write ordering on a collision, and the reset returning a populated bank to zero.

// File: rtl/wmask_regbank.sv
`timescale 1ns/1ps
module wmask_regbank #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int NUM_CTRL  = 7,
  parameter int STAT_WORD = 8,
  parameter int CAL_BIT   = 6,
  parameter int DLL_BIT   = 5,
  parameter int PHY_REG   = 6,
  parameter int PWR_BIT   = 0,
  parameter int DLLEN_BIT = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [2*DATA_W-1:0]        wdata,
  input  logic                       wr_en,
  input  logic                       rd_en,
  output logic [2*DATA_W-1:0]        rdata,
  input  logic                       cal_done_i,
  input  logic                       dll_rdy_i,
  output logic [NUM_CTRL*DATA_W-1:0] ctrl_o,
  output logic                       pwr_on_o,
  output logic                       dll_en_o
);
  localparam int BUS_W = 2 * DATA_W;
  localparam int IDX_W = ADDR_W - 2;

  logic [DATA_W-1:0] regs [NUM_CTRL];
  logic [IDX_W-1:0]  word_idx;
  logic              aligned, ctrl_hit, stat_hit;
  logic [DATA_W-1:0] wmask, wbits;
  logic [DATA_W-1:0] rd_val;

  assign word_idx = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign ctrl_hit = aligned && (word_idx < IDX_W'(NUM_CTRL));
  assign stat_hit = aligned && (word_idx == IDX_W'(STAT_WORD));
  assign wmask    = wdata[BUS_W-1:DATA_W];
  assign wbits    = wdata[DATA_W-1:0];

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
    logic sel;
    assign sel = wr_en && ctrl_hit && (word_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[i] <= '0;
      else if (sel) regs[i] <= (regs[i] & ~wmask) | (wbits & wmask);
    end
    assign ctrl_o[i*DATA_W +: DATA_W] = regs[i];
  end

  always_comb begin
    rd_val = '0;
    if (ctrl_hit) begin
      for (int i = 0; i < NUM_CTRL; i++)
        if (word_idx == IDX_W'(i)) rd_val = regs[i];
    end else if (stat_hit) begin
      rd_val[CAL_BIT] = cal_done_i;
      rd_val[DLL_BIT] = dll_rdy_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= {{DATA_W{1'b0}}, rd_val};
  end

  assign pwr_on_o = regs[PHY_REG][PWR_BIT];
  assign dll_en_o = regs[PHY_REG][DLLEN_BIT];
endmodule

// File: rtl/wmask_regbank_chk.sv
`timescale 1ns/1ps
module wmask_regbank_chk #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int NUM_CTRL  = 7,
  parameter int STAT_WORD = 8,
  parameter int CAL_BIT   = 6,
  parameter int DLL_BIT   = 5,
  parameter int PHY_REG   = 6,
  parameter int PWR_BIT   = 0,
  parameter int DLLEN_BIT = 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          addr,
  input logic [2*DATA_W-1:0]        wdata,
  input logic                       wr_en,
  input logic                       rd_en,
  input logic [2*DATA_W-1:0]        rdata,
  input logic                       cal_done_i,
  input logic                       dll_rdy_i,
  input logic [NUM_CTRL*DATA_W-1:0] ctrl_o,
  input logic                       pwr_on_o,
  input logic                       dll_en_o
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_WORD * 4);
  localparam logic [ADDR_W-1:0] LAST_CTRL = ADDR_W'((NUM_CTRL - 1) * 4);
  localparam logic [ADDR_W-1:0] PHY_ADDR  = ADDR_W'(PHY_REG * 4);

  logic in_ctrl, mapped;
  logic [NUM_CTRL*DATA_W-1:0] wide_mask;
  assign in_ctrl   = (addr[1:0] == 2'b00) && (addr <= LAST_CTRL);
  assign mapped    = in_ctrl || (addr == STAT_ADDR);
  assign wide_mask = {NUM_CTRL{wdata[2*DATA_W-1:DATA_W]}};

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (ctrl_o == '0 && rdata == '0 && !pwr_on_o && !dll_en_o));

  a_r2_masked_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((ctrl_o ^ $past(ctrl_o)) & ~$past(wide_mask)) == '0));

  a_r6_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && in_ctrl) |=> $stable(ctrl_o));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[2*DATA_W-1:DATA_W] == '0);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  a_r5_status: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == STAT_ADDR) |=>
      (rdata[CAL_BIT] == $past(cal_done_i) && rdata[DLL_BIT] == $past(dll_rdy_i)
       && $countones(rdata) == $countones({$past(cal_done_i), $past(dll_rdy_i)})));

  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> rdata == '0);

  a_r8_pwr_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on_o) |-> $past(wr_en && addr == PHY_ADDR
                              && wdata[DATA_W+PWR_BIT] && wdata[PWR_BIT]));

  a_r8_dll_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_en_o) |-> $past(wr_en && addr == PHY_ADDR
                              && wdata[DATA_W+DLLEN_BIT] && wdata[DLLEN_BIT]));
endmodule

bind wmask_regbank wmask_regbank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL), .STAT_WORD(STAT_WORD),
  .CAL_BIT(CAL_BIT), .DLL_BIT(DLL_BIT), .PHY_REG(PHY_REG),
  .PWR_BIT(PWR_BIT), .DLLEN_BIT(DLLEN_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .rdata(rdata), .cal_done_i(cal_done_i), .dll_rdy_i(dll_rdy_i),
  .ctrl_o(ctrl_o), .pwr_on_o(pwr_on_o), .dll_en_o(dll_en_o)
);

// File: tb/wmask_regbank_test.sv
`timescale 1ns/1ps
module wmask_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] rdata;
  logic        cal_done_i = 1'b0, dll_rdy_i = 1'b0;
  logic [111:0] ctrl_o;
  logic        pwr_on_o, dll_en_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wmask_regbank uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .cal_done_i(cal_done_i), .dll_rdy_i(dll_rdy_i),
    .ctrl_o(ctrl_o), .pwr_on_o(pwr_on_o), .dll_en_o(dll_en_o)
  );

  // {address, write word, expected read-back of that address}
  localparam logic [55:0] VEC [10] = '{
    {8'h00, 32'hFFFF_A5A5, 16'hA5A5},
    {8'h00, 32'h00F0_0000, 16'hA505},
    {8'h00, 32'h0000_FFFF, 16'hA505},
    {8'h04, 32'hFFFF_1234, 16'h1234},
    {8'h08, 32'h0F0F_FFFF, 16'h0F0F},
    {8'h0C, 32'h8001_FFFF, 16'h8001},
    {8'h10, 32'hFFFF_CAFE, 16'hCAFE},
    {8'h14, 32'hFF00_BEEF, 16'hBE00},
    {8'h18, 32'h0003_0001, 16'h0001},
    {8'h04, 32'h00FF_00AB, 16'h12AB}
  };
  localparam logic [15:0] FINAL [7] = '{16'hA505, 16'h12AB, 16'h0F0F, 16'h8001,
                                        16'hCAFE, 16'hBE00, 16'h0001};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] q);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; q = rdata;
  endtask

  task automatic check_bank(input string req);
    logic [31:0] q;
    for (int k = 0; k < 7; k++) begin
      rd(8'(k * 4), q);
      check(req, q, {16'h0, FINAL[k]});
    end
  endtask

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    check("R1 reset ctrl", ctrl_o[31:0], 32'h0);
    check("R1 reset rdata", rdata, 32'h0);
    check("R1 reset phy", {30'h0, pwr_on_o, dll_en_o}, 32'h0);
    rst_n = 1'b1;

    for (int v = 0; v < 10; v++) begin
      wr(VEC[v][55:48], VEC[v][47:16]);
      rd(VEC[v][55:48], q);
      check("R2 R4 masked write", q, {16'h0, VEC[v][15:0]});
    end

    check_bank("R3 register isolation");
    check("R8 phy after 0x0001", {30'h0, pwr_on_o, dll_en_o}, 32'h2);

    wr(8'h18, 32'h0002_0002);
    check("R8 dll enable", {30'h0, pwr_on_o, dll_en_o}, 32'h3);
    wr(8'h18, 32'h0003_0000);
    check("R8 both cleared", {30'h0, pwr_on_o, dll_en_o}, 32'h0);
    wr(8'h18, 32'h0001_0001);
    check("R8 power restored", {30'h0, pwr_on_o, dll_en_o}, 32'h2);

    cal_done_i = 1'b1; dll_rdy_i = 1'b0; rd(8'h20, q); check("R5 cal only", q, 32'h40);
    cal_done_i = 1'b0; dll_rdy_i = 1'b1; rd(8'h20, q); check("R5 dll only", q, 32'h20);
    cal_done_i = 1'b1; dll_rdy_i = 1'b1; rd(8'h20, q); check("R5 both", q, 32'h60);
    cal_done_i = 1'b0; dll_rdy_i = 1'b0; rd(8'h20, q); check("R5 none", q, 32'h0);

    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h19, 32'hFFFF_FFFE);
    wr(8'hFC, 32'hFFFF_FFFF);
    check_bank("R6 ignored writes");
    rd(8'h20, q); check("R6 status after write", q, 32'h0);

    rd(8'h1C, q); check("R7 unmapped 0x1C", q, 32'h0);
    rd(8'h02, q); check("R7 unaligned 0x02", q, 32'h0);
    rd(8'hFC, q); check("R7 unmapped 0xFC", q, 32'h0);

    rd(8'h0C, q);
    repeat (3) @(negedge clk);
    check("R4 rdata holds", rdata, 32'h8001);

    @(negedge clk); addr = 8'h10; wdata = 32'hFFFF_0000; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R9 read before write", rdata, 32'h0000_CAFE);
    rd(8'h10, q); check("R9 write landed", q, 32'h0);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset ctrl", ctrl_o[111:80], 32'h0);
    check("R1 mid-run reset low", ctrl_o[31:0], 32'h0);
    check("R1 mid-run reset phy", {30'h0, pwr_on_o, dll_en_o}, 32'h0);
    rst_n = 1'b1;
    rd(8'h04, q); check("R1 reg cleared", q, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule